// File: doc/BRIEF.md
# Per-Line GPIO Interrupt Condition Detector

This block watches a vector of already-synchronised pad levels and decides, line by line, when an interrupt condition has occurred. Each line has a 2-bit condition code that selects low level, high level, rising edge or falling edge. It also has an override bit that makes the line respond to any change of level instead. A detected condition sets a sticky status bit for that line. The bit stays set until software clears it through the clear vector.

Edges are found by comparing the current sample with a registered copy of the previous one. The previous sample is loaded on the first clock after reset, so a pad that is already high or low when reset ends does not look like an edge. Level conditions are evaluated on every cycle. A change of condition code or override therefore takes effect on the next clock edge, even if the input does not move.

The mask does not gate detection. It only qualifies which status bits drive the single interrupt output. Register decoding, pad synchronisation and the direction of the pins are handled elsewhere. Lines used as outputs still feed the detector from their pad sample.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `status` is all zeros and `irq` is 0.
- R2: With override 0 and code 2'b00 in `cond_cfg[2i+1:2i]`, a low `pad_now[i]` at a clock edge sets `status[i]` after that edge.
- R3: With override 0 and code 2'b01, a high `pad_now[i]` at a clock edge sets `status[i]` after that edge.
- R4: With override 0 and code 2'b10, a 0-to-1 change between the previous and current sample of line i sets `status[i]`. A steady level does not set it.
- R5: With override 0 and code 2'b11, a 1-to-0 change between the previous and current sample of line i sets `status[i]`. A steady level does not set it.
- R6: With `any_edge[i]` = 1, the code of line i is ignored. Any change of level sets `status[i]`, and a steady level, whatever the code, does not.
- R7: A set status bit stays set until a clock edge at which `clr[i]` = 1 and no condition is detected on line i. It is then 0 after that edge.
- R8: If a condition is detected on line i at the same edge at which `clr[i]` = 1, `status[i]` is 1 after that edge.
- R9: `irq_mask` has no effect on `status`. `irq` is 1 exactly when some bit is set in both `status` and `irq_mask`.
- R10: Edge detection compares against a sample registered at the previous clock edge. At the first edge after reset the sample is loaded and no edge is reported, whatever the pad level.
- R11: Changing `cond_cfg` to a level code that matches the current steady pad level sets the status bit at the next edge, without any input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_now | input | LINES | Current synchronised pad levels |
| cond_cfg | input | 2*LINES | Condition code per line, line i at bits [2i+1:2i] |
| any_edge | input | LINES | Per-line override: detect any change of level |
| irq_mask | input | LINES | Per-line enable of the interrupt output |
| clr | input | LINES | Per-line status clear, active high |
| status | output | LINES | Sticky detected-condition bits |
| irq | output | 1 | OR of status bits enabled by irq_mask |

## Verification
A clear and a new detection can fall on the same line in the same cycle. A level code with a matching pad, or an edge that arrives together with a clear, both provoke this. Directed steps assert `clr` on every line while some lines have an active condition and others do not. The set lines must stay set and the idle ones must drop. Random steps with sparse clears mixed into changing pads and codes meet this collision many times, and a bench model judges each cycle from the requirements.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES-1:0]   pad_now,
  input  logic [2*LINES-1:0] cond_cfg,
  input  logic [LINES-1:0]   any_edge,
  input  logic [LINES-1:0]   irq_mask,
  input  logic [LINES-1:0]   clr,
  output logic [LINES-1:0]   status,
  output logic               irq
);

  logic [LINES-1:0] pad_prev;
  logic [LINES-1:0] hit;
  logic             primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_prev <= '0;
      primed   <= 1'b0;
    end else begin
      pad_prev <= pad_now;
      primed   <= 1'b1;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic rise, fall;
    assign rise = primed & ~pad_prev[i] &  pad_now[i];
    assign fall = primed &  pad_prev[i] & ~pad_now[i];

    always_comb begin
      if (any_edge[i]) begin
        hit[i] = rise | fall;
      end else begin
        unique case (cond_cfg[2*i +: 2])
          2'b00:   hit[i] = ~pad_now[i];
          2'b01:   hit[i] =  pad_now[i];
          2'b10:   hit[i] = rise;
          default: hit[i] = fall;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr) | hit;
  end

  assign irq = |(status & irq_mask);

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int LINES = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LINES-1:0]   pad_now,
  input logic [2*LINES-1:0] cond_cfg,
  input logic [LINES-1:0]   any_edge,
  input logic [LINES-1:0]   irq_mask,
  input logic [LINES-1:0]   clr,
  input logic [LINES-1:0]   status,
  input logic               irq
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (status == '0 && !irq));

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((($past(status) & ~$past(clr)) & ~status) == '0));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !irq);

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    // R2
    low_level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_edge[i] && cond_cfg[2*i +: 2] == 2'b00 && !pad_now[i]) |=> status[i]);
    // R3
    high_level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_edge[i] && cond_cfg[2*i +: 2] == 2'b01 && pad_now[i]) |=> status[i]);
  end

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pad_now(pad_now), .cond_cfg(cond_cfg),
  .any_edge(any_edge), .irq_mask(irq_mask), .clr(clr),
  .status(status), .irq(irq)
);

// File: tb/gpio_irq_detect_tb.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic [N-1:0] pad = '0, ae = '0, mask = '0, clr = '0;
  logic [2*N-1:0] cfg = '0;
  logic [N-1:0] status;
  logic         irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [N-1:0] m_prev = '0, m_status = '0;
  logic         m_primed = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_detect #(.LINES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .pad_now(pad), .cond_cfg(cfg),
    .any_edge(ae), .irq_mask(mask), .clr(clr), .status(status), .irq(irq)
  );

  function automatic logic [N-1:0] exp_hits(input logic [N-1:0] p, input logic [N-1:0] n,
                                            input logic [2*N-1:0] c, input logic [N-1:0] a,
                                            input logic pr);
    logic [N-1:0] h;
    for (int i = 0; i < N; i++) begin
      logic r, f;
      r = pr & ~p[i] & n[i];
      f = pr & p[i] & ~n[i];
      if (a[i]) h[i] = r | f;
      else case (c[2*i +: 2])
        2'b00: h[i] = ~n[i];
        2'b01: h[i] = n[i];
        2'b10: h[i] = r;
        default: h[i] = f;
      endcase
    end
    return h;
  endfunction

  function automatic logic [2*N-1:0] all_code(input logic [1:0] code);
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++) v[2*i +: 2] = code;
    return v;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] got_s, input logic got_i);
    checks++;
    if (got_s !== m_status) begin
      errors++;
      $display("FAIL %s status actual=%h expected=%h", tag, got_s, m_status);
    end
    checks++;
    if (got_i !== |(m_status & mask)) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", tag, got_i, |(m_status & mask));
    end
  endtask

  // inputs already driven after a negedge; clock once and compare
  task automatic step(input string tag);
    m_status = (m_status & ~clr) | exp_hits(m_prev, pad, cfg, ae, m_primed);
    m_prev   = pad;
    m_primed = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(tag, status, irq);
  endtask

  task automatic clear_all();
    clr = '1; ae = '0; cfg = all_code(2'b10);
    step("R7 clear");
    clr = '0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    pad = '1; cfg = all_code(2'b10);
    check("R1 reset", status, irq);
    rst_n = 1'b1;
    // R10: high pads with rising code at first edge give no edge
    step("R10 first edge");
    step("R1 post-reset idle");

    // R5 falling edge on every line
    cfg = all_code(2'b11);
    pad = '0;
    step("R5 fall");
    step("R7 sticky after fall");
    clr = '1;
    step("R7 clear when idle");
    clr = '0;

    // R4 rising on lower half
    cfg = all_code(2'b10);
    pad = 32'h0000_FFFF;
    step("R4 rise");
    step("R4 steady no new set");
    clear_all();

    // R2 low level, then collision with clear
    cfg = all_code(2'b00);
    step("R2 low level");
    clr = '1;
    step("R8 set beats clear");
    clr = '0;

    // R3 high level with clear on all lines
    cfg = all_code(2'b01);
    pad = 32'hF0F0_F0F0;
    clr = '1;
    step("R3 high level with clear");
    clr = '0;

    // R9 mask only gates irq
    mask = '0;          step("R9 mask none");
    mask = 32'h0000_0001; step("R9 mask unset bit");
    mask = 32'h0000_0010; step("R9 mask set bit");
    mask = '1;

    // R6 override: steady high with code 01 must not set
    clear_all();
    pad = '1; cfg = all_code(2'b01); ae = '1; clr = '1;
    step("R6 override settle");
    clr = '0;
    step("R6 steady level ignored");
    // falling edge with rising code must set
    cfg = all_code(2'b10); pad = 32'h00FF_00FF;
    step("R6 any change");
    ae = '0;

    // R11 reconfigure with steady level
    clear_all();
    pad = '0; cfg = all_code(2'b11);
    step("R11 before");
    cfg = all_code(2'b00);
    step("R11 code change sets");

    // random mix
    for (int k = 0; k < 400; k++) begin
      pad  = $urandom;
      cfg  = {$urandom, $urandom};
      ae   = $urandom & $urandom;
      mask = $urandom;
      clr  = (k % 3 == 0) ? ($urandom | $urandom) : ($urandom & $urandom & $urandom);
      step("R8 random mix");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule